// File: doc/BRIEF.md
# Configuration Boot Source Sequencer

This block runs the start-up configuration of a programmable device. When the configuration reset input goes high, it samples a boot-order code. The code picks one or two non-volatile sources to load the bitstream from: an internal one-time memory or an external flash read over a master SPI link. The block then tries those sources in order. For each attempt it issues a single-cycle fetch request and waits for a pass or fail answer. If an attempt passes, the device is done configuring. If every attempt fails, the block stays in configuration for good.

A second way in handles blank devices. While the configuration reset input is held low, an external master may present an activation key. The block sees it as a key-match strobe. If the strobe arrives within a fixed window after power-up, the block enters slave programming mode and starts no fetch of its own. The bus transfers and the checking of the bitstream sit outside this block. Here they are seen only as request and response strobes.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `rst_n` is low and until the first fetch, `fetch_req`, `cfg_done`, `slave_mode` and `mspi_en` are 0 and `in_config` is 1.
- R2: The boot-order code is sampled on the clock edge where `creset_n` is first seen high. The attempt order for each code is: 0 = internal then external (the unprogrammed default), 1 = internal only, 2 = external only, 3 = external then internal, 4 = external then external. `fetch_src` reads 0 for internal and 1 for external while `fetch_req` is high.
- R3: Codes 5, 6 and 7 behave exactly like code 1: a single internal attempt.
- R4: `mspi_en` is 1 from the first request until a fetch passes, for every order except internal only. For internal only it stays 0.
- R5: Each request lasts exactly one cycle. The first request is high in the cycle after the edge that sees `creset_n` high. After a fail, the next request is high in the cycle after the edge that samples the fail.
- R6: A `fetch_ok` sampled while a response is awaited raises `cfg_done` and drops `in_config` on that same edge. `fetch_ok` wins if `fail` is high too. `cfg_done` then stays high until `rst_n`.
- R7: If the last attempt fails, the block issues no more requests, `cfg_done` stays 0 and `in_config` stays 1.
- R8: A `key_match` pulse sampled while `creset_n` is low, and fewer than `CLK_KHZ*95/10` cycles after reset release, sets `slave_mode` on that edge. `slave_mode` stays set until reset, and no fetch is ever issued while it is set.
- R9: A `key_match` pulse that comes after the window, or while `creset_n` is high, leaves `slave_mode` at 0. The normal boot then proceeds.
- R10: `mspi_persist` has no effect on `mspi_en`, on the attempt order or on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| creset_n | input | 1 | Configuration reset pin, low holds off boot |
| boot_order | input | 3 | Boot-order code |
| mspi_persist | input | 1 | Master SPI persistence setting (no effect) |
| key_match | input | 1 | Activation key matched strobe |
| fetch_ok | input | 1 | Current attempt found valid data |
| fetch_fail | input | 1 | Current attempt found no valid data |
| fetch_req | output | 1 | One-cycle request to fetch from `fetch_src` |
| fetch_src | output | 1 | Source of the request: 0 internal, 1 external |
| mspi_en | output | 1 | Master SPI link enabled |
| cfg_done | output | 1 | Configuration loaded |
| in_config | output | 1 | Still in configuration state |
| slave_mode | output | 1 | Slave programming mode entered |

## Verification
Every result is one register stage behind its cause. A request shows one cycle after `creset_n` goes high or after a fail is sampled. `cfg_done` rises on the edge that samples `fetch_ok`, and `slave_mode` rises on the edge that samples an accepted key. The bench drives inputs on falling edges and reads the outputs on the next falling edge. It looks for the first request within a bounded count of cycles, then expects the request to be gone one falling edge later. The no-further-request and ignored-key results are watched over a stretch of cycles longer than any legal response delay.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

    typedef enum logic [2:0] {
        ORD_INT_EXT = 3'd0,
        ORD_INT     = 3'd1,
        ORD_EXT     = 3'd2,
        ORD_EXT_INT = 3'd3,
        ORD_EXT_EXT = 3'd4
    } boot_order_e;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_REQ,
        ST_RSP,
        ST_DONE,
        ST_STUCK
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic [2:0] order;
        logic       idx;
    } seq_reg_t;

    typedef struct packed {
        logic       slave;
        logic [31:0] cnt;
    } key_reg_t;

endpackage

// File: rtl/cfg_order_decode.sv
module cfg_order_decode
    import cfg_boot_pkg::*;
(
    input  logic [2:0] code,
    output logic       src0,
    output logic       src1,
    output logic       two_src,
    output logic       uses_ext
);
    always_comb begin
        src0    = SRC_INT;
        src1    = SRC_INT;
        two_src = 1'b0;
        case (code)
            ORD_INT_EXT: begin src0 = SRC_INT; src1 = SRC_EXT; two_src = 1'b1; end
            ORD_EXT:     begin src0 = SRC_EXT; end
            ORD_EXT_INT: begin src0 = SRC_EXT; src1 = SRC_INT; two_src = 1'b1; end
            ORD_EXT_EXT: begin src0 = SRC_EXT; src1 = SRC_EXT; two_src = 1'b1; end
            default:     begin src0 = SRC_INT; end
        endcase
        uses_ext = (src0 == SRC_EXT) | (two_src & (src1 == SRC_EXT));
    end
endmodule

// File: rtl/cfg_key_window.sv
module cfg_key_window
    import cfg_boot_pkg::*;
#(
    parameter int CLK_KHZ = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic creset_n,
    input  logic key_match,
    input  logic armed,
    output logic slave_mode
);
    localparam int WIN = (CLK_KHZ * 95) / 10;
    localparam int CW  = $clog2(WIN + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          slave_d, slave_q;
    logic          in_win;

    always_comb begin
        cnt_d   = cnt_q;
        slave_d = slave_q;
        in_win  = (cnt_q < CW'(WIN));
        if (in_win) cnt_d = cnt_q + CW'(1);
        if (armed && key_match && !creset_n && in_win) slave_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            slave_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            slave_q <= slave_d;
        end
    end

    assign slave_mode = slave_q;

    // R8: slave entry only from a key seen with the reset pin low
    p_key_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slave_mode) |-> $past(key_match && !creset_n));
    // R8: slave mode is sticky
    p_slave_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |=> slave_mode);
    // R9: no entry once the window has closed
    p_window_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win && !slave_mode) |=> !slave_mode);
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
    import cfg_boot_pkg::*;
#(
    parameter int CLK_KHZ = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       creset_n,
    input  logic [2:0] boot_order,
    input  logic       mspi_persist,
    input  logic       key_match,
    input  logic       fetch_ok,
    input  logic       fetch_fail,
    output logic       fetch_req,
    output logic       fetch_src,
    output logic       mspi_en,
    output logic       cfg_done,
    output logic       in_config,
    output logic       slave_mode
);
    seq_reg_t q, d;
    logic src0, src1, two_src, uses_ext;
    logic unused_persist;

    assign unused_persist = mspi_persist;

    cfg_order_decode u_dec (
        .code     (q.order),
        .src0     (src0),
        .src1     (src1),
        .two_src  (two_src),
        .uses_ext (uses_ext)
    );

    cfg_key_window #(.CLK_KHZ(CLK_KHZ)) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .creset_n   (creset_n),
        .key_match  (key_match),
        .armed      (q.st == ST_WAIT),
        .slave_mode (slave_mode)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_WAIT: begin
                if (creset_n && !slave_mode) begin
                    d.st    = ST_REQ;
                    d.order = boot_order;
                    d.idx   = 1'b0;
                end
            end
            ST_REQ: d.st = ST_RSP;
            ST_RSP: begin
                if (fetch_ok) begin
                    d.st = ST_DONE;
                end else if (fetch_fail) begin
                    if (!q.idx && two_src) begin
                        d.idx = 1'b1;
                        d.st  = ST_REQ;
                    end else begin
                        d.st = ST_STUCK;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_WAIT;
            q.order <= ORD_INT_EXT;
            q.idx   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign fetch_req = (q.st == ST_REQ);
    assign fetch_src = q.idx ? src1 : src0;
    assign mspi_en   = uses_ext &&
                       (q.st == ST_REQ || q.st == ST_RSP || q.st == ST_STUCK);
    assign cfg_done  = (q.st == ST_DONE);
    assign in_config = !cfg_done;

    // R5: requests are single-cycle
    p_req_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);
    // R6: done only follows a passing response
    p_done_after_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(fetch_ok));
    // R6: done holds until reset
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);
    // R4: with the SPI link off, only internal requests
    p_int_without_spi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !mspi_en) |-> (fetch_src == SRC_INT));
    // R7: once stuck, no further requests
    p_stuck_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STUCK) |=> !fetch_req);
    // R8: no fetch in slave mode
    p_no_fetch_slave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> !fetch_req);
endmodule

// File: tb/sim_cfg_boot_seq.sv
module sim_cfg_boot_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0, creset_n = 1'b0, mspi_persist = 1'b0;
    logic key_match = 1'b0, fetch_ok = 1'b0, fetch_fail = 1'b0;
    logic [2:0] boot_order = 3'd0;
    logic fetch_req, fetch_src, mspi_en, cfg_done, in_config, slave_mode;
    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_boot_seq #(.CLK_KHZ(4)) u0 (
        .clk(clk), .rst_n(rst_n), .creset_n(creset_n), .boot_order(boot_order),
        .mspi_persist(mspi_persist), .key_match(key_match), .fetch_ok(fetch_ok),
        .fetch_fail(fetch_fail), .fetch_req(fetch_req), .fetch_src(fetch_src),
        .mspi_en(mspi_en), .cfg_done(cfg_done), .in_config(in_config),
        .slave_mode(slave_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] ord, input logic pers);
        @(negedge clk);
        rst_n = 1'b0; creset_n = 1'b0; key_match = 1'b0;
        fetch_ok = 1'b0; fetch_fail = 1'b0;
        boot_order = ord; mspi_persist = pers;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "fetch_req", int'(fetch_req), 0);
        chk("R1", "cfg_done", int'(cfg_done), 0);
        chk("R1", "slave_mode", int'(slave_mode), 0);
        chk("R1", "mspi_en", int'(mspi_en), 0);
        chk("R1", "in_config", int'(in_config), 1);
    endtask

    task automatic wait_req(output bit found);
        found = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (fetch_req) begin found = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic watch_quiet(input string req, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (fetch_req) seen++;
        end
        chk(req, "extra requests", seen, 0);
    endtask

    // ok_at: 0 = every attempt fails, n = attempt n passes
    task automatic boot_case(input string req, input logic [2:0] ord, input logic pers,
                             input int nsrc, input logic s0, input logic s1, input int ok_at);
        bit found;
        logic exp_mspi;
        exp_mspi = s0 | ((nsrc == 2) & s1);
        do_reset(ord, pers);
        creset_n = 1'b1;
        for (int a = 0; a < nsrc; a++) begin
            wait_req(found);
            chk("R5", "request seen", int'(found), 1);
            chk(req, "fetch_src", int'(fetch_src), int'((a == 0) ? s0 : s1));
            chk("R4", "mspi_en", int'(mspi_en), int'(exp_mspi));
            @(negedge clk);
            chk("R5", "request width", int'(fetch_req), 0);
            if (ok_at == a + 1) fetch_ok = 1'b1; else fetch_fail = 1'b1;
            @(negedge clk);
            fetch_ok = 1'b0; fetch_fail = 1'b0;
            if (ok_at == a + 1) begin
                chk("R6", "cfg_done", int'(cfg_done), 1);
                chk("R6", "in_config", int'(in_config), 0);
                break;
            end
        end
        if (ok_at == 0) begin
            watch_quiet("R7", 15);
            chk("R7", "cfg_done", int'(cfg_done), 0);
            chk("R7", "in_config", int'(in_config), 1);
            chk("R4", "mspi_en while stuck", int'(mspi_en), int'(exp_mspi));
        end else begin
            repeat (5) @(negedge clk);
            chk("R6", "cfg_done sticky", int'(cfg_done), 1);
        end
    endtask

    task automatic key_early;
        do_reset(3'd0, 1'b0);
        repeat (4) @(negedge clk);
        key_match = 1'b1;
        @(negedge clk);
        key_match = 1'b0;
        chk("R8", "slave_mode after key", int'(slave_mode), 1);
        creset_n = 1'b1;
        watch_quiet("R8", 15);
        chk("R8", "slave_mode held", int'(slave_mode), 1);
        chk("R8", "in_config", int'(in_config), 1);
    endtask

    task automatic key_late;
        bit found;
        do_reset(3'd1, 1'b0);
        repeat (50) @(negedge clk);
        key_match = 1'b1;
        @(negedge clk);
        key_match = 1'b0;
        chk("R9", "late key slave_mode", int'(slave_mode), 0);
        creset_n = 1'b1;
        wait_req(found);
        chk("R9", "boot after late key", int'(found), 1);
    endtask

    task automatic key_high;
        bit found;
        do_reset(3'd2, 1'b0);
        creset_n = 1'b1;
        key_match = 1'b1;
        @(negedge clk);
        key_match = 1'b0;
        chk("R9", "key with pin high", int'(slave_mode), 0);
        wait_req(found);
        chk("R9", "boot with pin high", int'(found), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        boot_case("R2", 3'd0, 1'b0, 2, 1'b0, 1'b1, 2);
        boot_case("R2", 3'd1, 1'b0, 1, 1'b0, 1'b0, 1);
        boot_case("R2", 3'd2, 1'b0, 1, 1'b1, 1'b0, 0);
        boot_case("R2", 3'd3, 1'b0, 2, 1'b1, 1'b0, 0);
        boot_case("R2", 3'd4, 1'b1, 2, 1'b1, 1'b1, 2);
        boot_case("R3", 3'd6, 1'b0, 1, 1'b0, 1'b0, 0);
        boot_case("R3", 3'd7, 1'b0, 1, 1'b0, 1'b0, 1);
        boot_case("R10", 3'd1, 1'b1, 1, 1'b0, 1'b0, 1);
        boot_case("R10", 3'd3, 1'b1, 2, 1'b1, 1'b0, 2);
        key_early();
        key_late();
        key_high();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule